// File: doc/BRIEF.md
# Pin Interrupt Channel with Half-Port Assignment

This block is one interrupt channel that watches external pins and raises a single interrupt line. It does not watch individual pins chosen one by one. Each of its four byte lanes is bound to one 8-pin half-port taken from a vector of `NUM_HALF` source half-ports. That gives up to 32 watched pins per channel. The channel works apart from any GPIO direction or data logic. The pins are taken as already synchronous to `clk`.

Every watched pin can raise a request in one of two ways:
- **Edge mode:** the request is caught and held in a latch.
- **Level mode:** the request follows the pin.

Polarity is set per pin. The channel interrupt is the OR of the held requests that are also unmasked. Mask, edge-mode and inversion bits each sit behind two write addresses: one address sets bits, the other clears them. Software can always read the raw latch and the mapped pin levels, whatever the mask.

Register word addresses:

| Address | Write action | Read value |
|---|---|---|
| 0 | set mask bits | mask |
| 1 | clear mask bits | mask |
| 2 | set edge-mode bits | edge mode |
| 3 | clear edge-mode bits | edge mode |
| 4 | set inversion bits | inversion |
| 5 | clear inversion bits | inversion |
| 6 | clear request latch bits | unmasked requests |
| 7 | clear request latch bits | raw latch |
| 8 | half-port assignment | half-port assignment |
| 9 | none | pin state |

Writes take effect at the clock edge. Reads are combinational from `regAddr`.

Top module: `pint_channel`

## Requirements
- R1: After reset, every readable word (addresses 0 to 9) reads zero and `irq` is low. This means mask, edge mode and inversion are cleared, the latch is empty and every lane is unassigned.
- R2: Lane l (pins 8l..8l+7) takes its selector code from bits [8l +: SEL_W] of the assignment word at address 8. This word reads back as written, with the other bits zero. Code k in 1..NUM_HALF selects source half-port k-1, which is `pins[8(k-1) +: 8]`. Code 0, or any code above NUM_HALF, leaves the lane unassigned. An unassigned lane reads 0 in the pin-state word and never raises a request, whatever its polarity.
- R3: Address 9 reads the mapped pin levels before inversion, whatever the mask and mode.
- R4: An inversion bit of 1 inverts that pin before detection. Edge mode then catches falling transitions, and level mode is active while the pin is low.
- R5: In edge mode (edge bit 1), a latch bit sets when the active level goes from 0 in one clock sample to 1 in the next. The bit then holds until it is cleared.
- R6: In level mode (edge bit 0), a latch bit equals the active level sampled at the latest clock edge.
- R7: Writing ones to address 6 or 7 clears those edge-mode latch bits. If a new edge arrives in the same cycle as its clear, the bit stays set.
- R8: Addresses 0, 2 and 4 set the written one-bits of the mask, edge-mode and inversion words. Addresses 1, 3 and 5 clear them. Bits written as zero are left unchanged, and each word reads back at both of its addresses.
- R9: Address 6 reads the latch ANDed with the mask. Address 7 reads the raw latch whatever the mask.
- R10: `irq` is high exactly when some latch bit and its mask bit are both 1. It changes at the same edge as the latch.
- R11: A write that changes a lane's selector code clears that lane's latch bits. Edge detection is held off for that lane on the next sample, so the switch itself never raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| pins | input | 8*NUM_HALF | Source half-ports; half-port h at bits [8h +: 8] |
| irq | output | 1 | Channel interrupt |

## Verification
The bench targets four cases:
- **Clear in the same cycle as a new edge.** A design that lets the clear win would lose that request.
- **Lane reassigned to a half-port already high.** A design without the hold-off would report a phantom edge.
- **Out-of-range selector codes under inversion.** A design that does not gate unassigned lanes would read those lanes as active-low and fire.
- **Falling edges with inversion, and masked reads.** These show whether the latch value is hidden by the mask, or whether edge detection runs before inversion.

// File: rtl/pint_pkg.sv
package pint_pkg;
  localparam int PIN_N  = 32;
  localparam int LANE_W = 8;
  localparam int LANE_N = PIN_N / LANE_W;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_MASK_SET = 4'd0;
  localparam logic [ADDR_W-1:0] A_MASK_CLR = 4'd1;
  localparam logic [ADDR_W-1:0] A_EDGE_SET = 4'd2;
  localparam logic [ADDR_W-1:0] A_EDGE_CLR = 4'd3;
  localparam logic [ADDR_W-1:0] A_INV_SET  = 4'd4;
  localparam logic [ADDR_W-1:0] A_INV_CLR  = 4'd5;
  localparam logic [ADDR_W-1:0] A_REQ      = 4'd6;
  localparam logic [ADDR_W-1:0] A_LATCH    = 4'd7;
  localparam logic [ADDR_W-1:0] A_ASSIGN   = 4'd8;
  localparam logic [ADDR_W-1:0] A_PINS     = 4'd9;

  // strobes from register control to the detection datapath
  typedef struct packed {
    logic [PIN_N-1:0]  clrBits;
    logic [LANE_N-1:0] flushLane;
  } pint_strb_t;
endpackage

// File: rtl/pint_ctrl.sv
module pint_ctrl
  import pint_pkg::*;
#(
  parameter int NUM_HALF = 6,
  parameter int SEL_W    = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWe,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [PIN_N-1:0]        regWrData,
  output logic [PIN_N-1:0]        regRdData,
  input  logic [PIN_N-1:0]        latchQ,
  input  logic [PIN_N-1:0]        pinState,
  output logic [PIN_N-1:0]        maskQ,
  output logic [PIN_N-1:0]        edgeQ,
  output logic [PIN_N-1:0]        invQ,
  output logic [LANE_N*SEL_W-1:0] asgSel,
  output logic [LANE_N-1:0]       laneValid,
  output pint_strb_t              strb
);
  localparam logic [SEL_W-1:0] MAX_CODE = SEL_W'(NUM_HALF);

  logic [LANE_N*SEL_W-1:0] asgQ;
  logic [LANE_N*SEL_W-1:0] asgNext;
  logic [LANE_N-1:0]       laneChanged;
  logic [PIN_N-1:0]        asgRead;
  logic                    wrAssign;

  assign wrAssign = regWe && (regAddr == A_ASSIGN);

  for (genvar l = 0; l < LANE_N; l++) begin : g_lane
    logic [SEL_W-1:0] cur;
    assign cur = asgQ[l*SEL_W +: SEL_W];
    assign asgNext[l*SEL_W +: SEL_W] = regWrData[l*LANE_W +: SEL_W];
    assign laneChanged[l] = wrAssign && (asgNext[l*SEL_W +: SEL_W] != cur);
    assign laneValid[l]   = (cur != '0) && (cur <= MAX_CODE);
    assign asgRead[l*LANE_W +: LANE_W] = LANE_W'(cur);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      edgeQ <= '0;
      invQ  <= '0;
      asgQ  <= '0;
    end else if (regWe) begin
      case (regAddr)
        A_MASK_SET: maskQ <= maskQ | regWrData;
        A_MASK_CLR: maskQ <= maskQ & ~regWrData;
        A_EDGE_SET: edgeQ <= edgeQ | regWrData;
        A_EDGE_CLR: edgeQ <= edgeQ & ~regWrData;
        A_INV_SET:  invQ  <= invQ | regWrData;
        A_INV_CLR:  invQ  <= invQ & ~regWrData;
        A_ASSIGN:   asgQ  <= asgNext;
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.clrBits   = (regWe && (regAddr == A_REQ || regAddr == A_LATCH)) ? regWrData : '0;
    strb.flushLane = laneChanged;
  end

  assign asgSel = asgQ;

  always_comb begin
    case (regAddr)
      A_MASK_SET, A_MASK_CLR: regRdData = maskQ;
      A_EDGE_SET, A_EDGE_CLR: regRdData = edgeQ;
      A_INV_SET,  A_INV_CLR:  regRdData = invQ;
      A_REQ:                  regRdData = latchQ & maskQ;
      A_LATCH:                regRdData = latchQ;
      A_ASSIGN:               regRdData = asgRead;
      A_PINS:                 regRdData = pinState;
      default:                regRdData = '0;
    endcase
  end
endmodule

// File: rtl/pint_datapath.sv
module pint_datapath
  import pint_pkg::*;
#(
  parameter int NUM_HALF = 6,
  parameter int SEL_W    = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_HALF*LANE_W-1:0] pins,
  input  logic [LANE_N*SEL_W-1:0]   asgSel,
  input  logic [LANE_N-1:0]         laneValid,
  input  logic [PIN_N-1:0]          maskQ,
  input  logic [PIN_N-1:0]          edgeQ,
  input  logic [PIN_N-1:0]          invQ,
  input  pint_strb_t                strb,
  output logic [PIN_N-1:0]          latchQ,
  output logic [PIN_N-1:0]          pinState,
  output logic                      irq
);
  logic [PIN_N-1:0]  validBits;
  logic [PIN_N-1:0]  quietBits;
  logic [PIN_N-1:0]  flushBits;
  logic [PIN_N-1:0]  active;
  logic [PIN_N-1:0]  prevQ;
  logic [PIN_N-1:0]  rise;
  logic [PIN_N-1:0]  latchNext;
  logic [LANE_N-1:0] quietQ;

  for (genvar l = 0; l < LANE_N; l++) begin : g_lane
    logic [LANE_W-1:0] laneRaw;
    always_comb begin
      laneRaw = '0;
      for (int h = 0; h < NUM_HALF; h++) begin
        if (asgSel[l*SEL_W +: SEL_W] == SEL_W'(h + 1))
          laneRaw = pins[h*LANE_W +: LANE_W];
      end
    end
    assign pinState[l*LANE_W +: LANE_W]  = laneRaw;
    assign validBits[l*LANE_W +: LANE_W] = {LANE_W{laneValid[l]}};
    assign quietBits[l*LANE_W +: LANE_W] = {LANE_W{quietQ[l]}};
    assign flushBits[l*LANE_W +: LANE_W] = {LANE_W{strb.flushLane[l]}};
  end

  assign active    = (pinState ^ invQ) & validBits;
  assign rise      = active & ~prevQ & ~quietBits;
  assign latchNext = ((edgeQ & ((latchQ & ~strb.clrBits) | rise)) |
                      (~edgeQ & active)) & ~flushBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ  <= '0;
      quietQ <= '0;
      latchQ <= '0;
    end else begin
      prevQ  <= active;
      quietQ <= strb.flushLane;
      latchQ <= latchNext;
    end
  end

  assign irq = |(latchQ & maskQ);
endmodule

// File: rtl/pint_channel.sv
module pint_channel
  import pint_pkg::*;
#(
  parameter int NUM_HALF = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWe,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [PIN_N-1:0]           regWrData,
  output logic [PIN_N-1:0]           regRdData,
  input  logic [NUM_HALF*LANE_W-1:0] pins,
  output logic                       irq
);
  localparam int SEL_W = $clog2(NUM_HALF + 1);

  logic [PIN_N-1:0]        maskQ;
  logic [PIN_N-1:0]        edgeQ;
  logic [PIN_N-1:0]        invQ;
  logic [PIN_N-1:0]        latchQ;
  logic [PIN_N-1:0]        pinState;
  logic [LANE_N*SEL_W-1:0] asgSel;
  logic [LANE_N-1:0]       laneValid;
  pint_strb_t              strb;

  pint_ctrl #(.NUM_HALF(NUM_HALF), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .latchQ(latchQ),
    .pinState(pinState), .maskQ(maskQ), .edgeQ(edgeQ), .invQ(invQ),
    .asgSel(asgSel), .laneValid(laneValid), .strb(strb)
  );

  pint_datapath #(.NUM_HALF(NUM_HALF), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .pins(pins), .asgSel(asgSel),
    .laneValid(laneValid), .maskQ(maskQ), .edgeQ(edgeQ), .invQ(invQ),
    .strb(strb), .latchQ(latchQ), .pinState(pinState), .irq(irq)
  );
endmodule

// File: rtl/pint_channel_checker.sv
module pint_channel_checker
  import pint_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [PIN_N-1:0]  regWrData,
  input logic [PIN_N-1:0]  regRdData,
  input logic              irq,
  input logic [PIN_N-1:0]  maskQ,
  input logic [PIN_N-1:0]  edgeQ,
  input logic [PIN_N-1:0]  latchQ,
  input logic [LANE_N-1:0] laneValid
);
  logic [PIN_N-1:0] validBits;
  always_comb begin
    for (int l = 0; l < LANE_N; l++)
      validBits[l*LANE_W +: LANE_W] = {LANE_W{laneValid[l]}};
  end

  AST_UNASSIGNED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (latchQ & ~validBits) == '0);                                            // R2

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ((edgeQ & $past(edgeQ) & $past(latchQ) & ~latchQ) != '0) |->
      $past(regWe && (regAddr == A_REQ || regAddr == A_LATCH || regAddr == A_ASSIGN))); // R5

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == A_MASK_SET) |=> ((maskQ & $past(regWrData)) == $past(regWrData))); // R8

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == A_MASK_CLR) |=> ((maskQ & $past(regWrData)) == '0)); // R8

  AST_ID_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == A_REQ) |-> ((regRdData & ~maskQ) == '0));                    // R9

  AST_IRQ_ID: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == A_REQ) |-> (irq == (regRdData != '0)));                      // R10
endmodule

bind pint_channel pint_channel_checker u_pint_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .irq(irq),
  .maskQ(maskQ), .edgeQ(edgeQ), .latchQ(latchQ), .laneValid(laneValid)
);

// File: tb/pint_channel_bench.sv
`timescale 1ns/1ps
module pint_channel_bench;
  localparam int NH = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [NH*8-1:0] pins = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] mMask = '0, mEdge = '0, mInv = '0, mLatch = '0, mPrev = '0, mAsg = '0;
  logic [3:0]  mQuiet = '0;

  always #2.5 clk = ~clk;

  pint_channel #(.NUM_HALF(NH)) u_pint_channel (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pins(pins), .irq(irq)
  );

  function automatic logic [31:0] validOf(logic [31:0] asg);
    logic [31:0] v = '0;
    for (int l = 0; l < 4; l++) begin
      int c = int'(asg[8*l +: 3]);
      if (c >= 1 && c <= NH) v[8*l +: 8] = 8'hFF;
    end
    return v;
  endfunction

  function automatic logic [31:0] mapOf(logic [31:0] asg, logic [NH*8-1:0] p);
    logic [31:0] m = '0;
    for (int l = 0; l < 4; l++) begin
      int c = int'(asg[8*l +: 3]);
      if (c >= 1 && c <= NH) m[8*l +: 8] = p[(c-1)*8 +: 8];
    end
    return m;
  endfunction

  function automatic logic [31:0] modelRead(logic [3:0] a);
    case (a)
      4'd0, 4'd1: return mMask;
      4'd2, 4'd3: return mEdge;
      4'd4, 4'd5: return mInv;
      4'd6:       return mLatch & mMask;
      4'd7:       return mLatch;
      4'd8:       return mAsg;
      4'd9:       return mapOf(mAsg, pins);
      default:    return '0;
    endcase
  endfunction

  function automatic string tagOf(logic [3:0] a);
    case (a)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: return "R8";
      4'd6: return "R9";
      4'd7: return "R5";
      4'd8: return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive a bus cycle, advance the model, compare at the next falling edge
  task automatic step(bit we, logic [3:0] a, logic [31:0] d);
    logic [31:0] act, rise, clr, nAsg, flush, quietB, nLatch;
    logic [3:0]  chg;
    regWe = we; regAddr = a; regWrData = d;
    act = (mapOf(mAsg, pins) ^ mInv) & validOf(mAsg);
    quietB = '0;
    for (int l = 0; l < 4; l++) if (mQuiet[l]) quietB[8*l +: 8] = 8'hFF;
    rise = act & ~mPrev & ~quietB;
    clr  = (we && (a == 4'd6 || a == 4'd7)) ? d : '0;
    nAsg = (we && a == 4'd8) ? (d & 32'h07070707) : mAsg;
    flush = '0;
    for (int l = 0; l < 4; l++) begin
      chg[l] = (nAsg[8*l +: 3] != mAsg[8*l +: 3]);
      if (chg[l]) flush[8*l +: 8] = 8'hFF;
    end
    nLatch = ((mEdge & ((mLatch & ~clr) | rise)) | (~mEdge & act)) & ~flush;
    @(posedge clk);
    mLatch = nLatch; mPrev = act; mQuiet = chg; mAsg = nAsg;
    if (we) begin
      case (a)
        4'd0: mMask = mMask | d;
        4'd1: mMask = mMask & ~d;
        4'd2: mEdge = mEdge | d;
        4'd3: mEdge = mEdge & ~d;
        4'd4: mInv  = mInv | d;
        4'd5: mInv  = mInv & ~d;
        default: ;
      endcase
    end
    @(negedge clk);
    cmp("R10 irq", {31'd0, irq}, {31'd0, |(mLatch & mMask)});
    cmp(tagOf(a), regRdData, modelRead(a));
    regWe = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int a = 0; a < 10; a++) begin
      regAddr = 4'(a); #1;
      cmp("R1 reset read", regRdData, 32'h0);
    end
    cmp("R1 reset irq", {31'd0, irq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // assignment and pin state
    pins = 48'hF0_33_22_11_3C_A5;
    step(1, 4'd8, 32'h06070201);
    step(0, 4'd9, 0); cmp("R3 pin state", regRdData, 32'hF0003CA5);
    step(0, 4'd8, 0); cmp("R2 assign readback", regRdData, 32'h06070201);
    // level mode, mask all
    step(1, 4'd0, 32'hFFFFFFFF);
    step(0, 4'd7, 0); cmp("R6 level latch", regRdData, 32'hF0003CA5);
    cmp("R10 irq level", {31'd0, irq}, 32'h1);
    step(1, 4'd4, 32'hFFFFFFFF);
    step(0, 4'd7, 0); cmp("R4 inverted level, R2 unassigned lane", regRdData, 32'h0F00C35A);
    step(1, 4'd5, 32'hFFFFFFFF);
    pins = '0;
    step(0, 4'd7, 0); cmp("R6 level low", regRdData, 32'h0);
    // edge mode
    step(1, 4'd2, 32'hFFFFFFFF);
    pins[0] = 1'b1; step(0, 4'd7, 0); cmp("R5 rise latched", regRdData, 32'h1);
    pins[0] = 1'b0; step(0, 4'd7, 0); cmp("R5 sticky", regRdData, 32'h1);
    step(1, 4'd1, 32'h1);
    step(0, 4'd6, 0); cmp("R9 masked id", regRdData, 32'h0);
    cmp("R10 irq masked", {31'd0, irq}, 32'h0);
    step(0, 4'd7, 0); cmp("R9 raw latch", regRdData, 32'h1);
    step(1, 4'd0, 32'h1);
    cmp("R10 irq unmasked", {31'd0, irq}, 32'h1);
    step(1, 4'd6, 32'h1); cmp("R7 cleared", regRdData, 32'h0);
    pins[1] = 1'b1; step(1, 4'd7, 32'h2); cmp("R7 set wins", regRdData, 32'h2);
    pins[1] = 1'b0; step(1, 4'd7, 32'hFFFFFFFF);
    // inverted edge
    pins[2] = 1'b1; step(0, 4'd7, 0);
    step(1, 4'd7, 32'hFFFFFFFF);
    step(1, 4'd4, 32'h4);
    step(0, 4'd7, 0); cmp("R4 no latch on inverted rise", regRdData, 32'h0);
    pins[2] = 1'b0; step(0, 4'd7, 0); cmp("R4 falling edge latched", regRdData, 32'h4);
    step(1, 4'd5, 32'h4);
    step(1, 4'd7, 32'hFFFFFFFF);
    // reassignment flush
    pins[15:8] = 8'hFF; pins[0] = 1'b1;
    step(0, 4'd7, 0); cmp("R5 lane rise", regRdData, 32'h0000FF01);
    step(1, 4'd7, 32'h0000FF00);
    step(1, 4'd8, 32'h06070202); cmp("R11 flush on change", regRdData, 32'h06070202);
    step(0, 4'd7, 0); cmp("R11 no phantom edge", regRdData, 32'h0);

    // random phase
    for (int i = 0; i < 1500; i++) begin
      logic [3:0]  a;
      logic [31:0] d;
      if ($urandom() % 3 == 0) pins = 48'({$urandom(), $urandom()});
      a = 4'($urandom() % 10);
      d = $urandom();
      if (a == 4'd8)
        for (int l = 0; l < 4; l++) d[8*l +: 8] = 8'($urandom() % 8);
      step($urandom() % 2 == 0, a, d);
      step(0, 4'($urandom() % 10), 0);
    end

    done = 1'b1;
    summary();
  end
endmodule